// File: doc/BRIEF.md
# Paged Program Counter with High-Address Latch

This block holds the 13-bit instruction fetch address for a small controller core whose program memory is split into pages. The core can read and write the low byte of the counter like an ordinary register. The upper bits cannot be written directly. Software loads them into a separate high-address latch register, and the counter picks them up only when an instruction changes the flow of control.

The latch bits are combined with the new address in two different ways. An operand jump or call supplies 11 address bits and takes only the top two bits from the latch. A computed jump, made by writing the low byte, supplies 8 bits and takes five bits from the latch. A call also offers the address of the next instruction to an external return stack, and a return reloads the whole counter from the value popped off that stack.

In normal sequencing the counter steps by one. It wraps from the top of the 8K address space back to zero.

Top module: `paged_pc`

## Requirements
- R1: While `rst_n` is low and right after reset, `fetch_addr` is 0x0000 and `latch_rd` is 0x00.
- R2: With only `adv` asserted, `fetch_addr` becomes the previous value plus one after the clock edge. It wraps from 0x1FFF to 0x0000 and crosses 256-word page and 2K-block boundaries without stopping.
- R3: When `jmp` wins arbitration, the new `fetch_addr[10:0]` is `opnd` and `fetch_addr[12:11]` is bits 4:3 of the latch.
- R4: When `call_stb` wins arbitration, the counter is loaded as in R3. In the same cycle `push_en` is 1 and `push_addr` is the current `fetch_addr` plus one, wrapping 0x1FFF to 0x0000. In every other cycle `push_en` is 0.
- R5: When `lo_wr` wins arbitration, the new `fetch_addr[7:0]` is `wr_data` and `fetch_addr[12:8]` is bits 4:0 of the latch.
- R6: A `latch_wr` pulse stores `wr_data[4:0]` in the latch. `latch_rd` shows the stored bits in positions 4:0, and bits 7:5 always read as 0. The latch changes only on `latch_wr`, never because of sequencing, jumps, calls, returns or low-byte writes.
- R7: `lo_rd` always equals `fetch_addr[7:0]`.
- R8: When `ret` is asserted, all 13 bits of `fetch_addr` are loaded from `pop_addr`.
- R9: Control strobes are ranked ret > call_stb > jmp > lo_wr > adv. The highest asserted one decides the next address. With none asserted, `fetch_addr` holds its value.
- R10: An address formed in the same cycle as a `latch_wr` uses the latch value from before that write. The new latch value takes effect from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| adv | input | 1 | Step to the next sequential address |
| jmp | input | 1 | Operand jump strobe |
| call_stb | input | 1 | Operand call strobe |
| opnd | input | 11 | Jump/call target operand |
| lo_wr | input | 1 | Write of the counter low byte (computed jump) |
| latch_wr | input | 1 | Write of the high-address latch |
| wr_data | input | 8 | Data for low-byte and latch writes |
| ret | input | 1 | Return strobe |
| pop_addr | input | 13 | Address popped from the return stack |
| fetch_addr | output | 13 | Current instruction fetch address |
| push_addr | output | 13 | Return address offered to the stack |
| push_en | output | 1 | Push request, high on a taken call |
| lo_rd | output | 8 | Read view of the counter low byte |
| latch_rd | output | 8 | Read view of the latch, upper bits zero |

## Verification
The hardest cases to reach are those where the latch contents disagree with the block or page the counter is currently in. A jump or computed jump must then land in a different 2K block or 256-word page than sequencing alone would ever reach. A latch write in the same cycle as the jump that consumes it is a further such case. The stimulus first parks the counter near 0x1FFF through a computed jump. It then reloads the latch with distinct patterns (0x1F, 0x0A, 0x13) before each jump, call and low-byte write, and issues one jump together with a latch write. Randomized strobe mixes follow, checked against a reference model.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
   // Source of the next fetch address, chosen by strobe priority
   typedef enum logic [2:0] {
      NXT_HOLD = 3'd0,
      NXT_INC  = 3'd1,
      NXT_LOW  = 3'd2,
      NXT_JMP  = 3'd3,
      NXT_CALL = 3'd4,
      NXT_RET  = 3'd5
   } nxt_src_e;
endpackage

// File: rtl/pc_latch_reg.sv
module pc_latch_reg #(
   parameter int REG_W   = 8,
   parameter int LATCH_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [LATCH_W-1:0] din,
   output logic [LATCH_W-1:0] q,
   output logic [REG_W-1:0]   rd
);
   localparam int PAD_W = REG_W - LATCH_W;

   if (LATCH_W < 1 || LATCH_W > REG_W) begin : g_bad_w
      $error("pc_latch_reg: LATCH_W must be in 1..REG_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= din;
   end

   if (PAD_W > 0) begin : g_pad
      assign rd = {{PAD_W{1'b0}}, q};
   end else begin : g_nopad
      assign rd = q;
   end

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q)); // R6
   AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(din))); // R6
endmodule

// File: rtl/pc_incr.sv
module pc_incr #(
   parameter int ADDR_W = 13,
   parameter int PAGE_W = 8,
   parameter bit SPLIT  = 1'b1
) (
   input  logic [ADDR_W-1:0] a,
   output logic [ADDR_W-1:0] y
);
   localparam int HI_W = ADDR_W - PAGE_W;

   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_w
      $error("pc_incr: PAGE_W must be in 1..ADDR_W-1");
   end

   if (SPLIT) begin : g_split
      // in-page byte increment with a carry into the page number
      logic [PAGE_W:0]   lo_sum;
      logic [HI_W-1:0]   hi_sum;
      assign lo_sum = {1'b0, a[PAGE_W-1:0]} + {{PAGE_W{1'b0}}, 1'b1};
      assign hi_sum = a[ADDR_W-1:PAGE_W] + {{(HI_W-1){1'b0}}, lo_sum[PAGE_W]};
      assign y      = {hi_sum, lo_sum[PAGE_W-1:0]};
   end else begin : g_flat
      assign y = a + {{(ADDR_W-1){1'b0}}, 1'b1};
   end
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
   import pcl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     adv,
   input  logic     jmp,
   input  logic     call_stb,
   input  logic     lo_wr,
   input  logic     ret,
   output nxt_src_e src,
   output logic     push_en
);
   always_comb begin
      if (ret)           src = NXT_RET;
      else if (call_stb) src = NXT_CALL;
      else if (jmp)      src = NXT_JMP;
      else if (lo_wr)    src = NXT_LOW;
      else if (adv)      src = NXT_INC;
      else               src = NXT_HOLD;
   end

   assign push_en = (src == NXT_CALL);

   AST_RET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ret |-> (src == NXT_RET) && !push_en); // R9
   AST_PUSH_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
      push_en |-> call_stb && !ret); // R4
endmodule

// File: rtl/paged_pc.sv
module paged_pc
   import pcl_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int OPND_W   = 11,
   parameter int REG_W    = 8,
   parameter bit INC_SPLIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              jmp,
   input  logic              call_stb,
   input  logic [OPND_W-1:0] opnd,
   input  logic              lo_wr,
   input  logic              latch_wr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              ret,
   input  logic [ADDR_W-1:0] pop_addr,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic [ADDR_W-1:0] push_addr,
   output logic              push_en,
   output logic [REG_W-1:0]  lo_rd,
   output logic [REG_W-1:0]  latch_rd
);
   localparam int LATCH_W = ADDR_W - REG_W;   // bits fed on a low-byte write
   localparam int BLK_W   = ADDR_W - OPND_W;  // bits fed on an operand jump
   localparam int BLK_LSB = OPND_W - REG_W;   // where those sit in the latch

   if (OPND_W <= REG_W || OPND_W >= ADDR_W) begin : g_bad_opnd
      $error("paged_pc: need REG_W < OPND_W < ADDR_W");
   end
   if (LATCH_W > REG_W) begin : g_bad_latch
      $error("paged_pc: latch must fit in one register");
   end

   logic [ADDR_W-1:0]  pc_q;
   logic [ADDR_W-1:0]  pc_d;
   logic [ADDR_W-1:0]  pc_inc;
   logic [LATCH_W-1:0] hi_q;
   nxt_src_e           src;

   pc_latch_reg #(.REG_W(REG_W), .LATCH_W(LATCH_W)) u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (latch_wr),
      .din  (wr_data[LATCH_W-1:0]),
      .q    (hi_q),
      .rd   (latch_rd)
   );

   pc_incr #(.ADDR_W(ADDR_W), .PAGE_W(REG_W), .SPLIT(INC_SPLIT)) u_inc (
      .a(pc_q),
      .y(pc_inc)
   );

   pc_next_sel u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .jmp     (jmp),
      .call_stb(call_stb),
      .lo_wr   (lo_wr),
      .ret     (ret),
      .src     (src),
      .push_en (push_en)
   );

   logic [ADDR_W-1:0] tgt_opnd;
   logic [ADDR_W-1:0] tgt_low;
   assign tgt_opnd = {hi_q[LATCH_W-1:BLK_LSB], opnd};
   assign tgt_low  = {hi_q, wr_data};

   always_comb begin
      unique case (src)
         NXT_RET:             pc_d = pop_addr;
         NXT_CALL, NXT_JMP:   pc_d = tgt_opnd;
         NXT_LOW:             pc_d = tgt_low;
         NXT_INC:             pc_d = pc_inc;
         default:             pc_d = pc_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_d;
   end

   assign fetch_addr = pc_q;
   assign push_addr  = pc_inc;
   assign lo_rd      = pc_q[REG_W-1:0];

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ret && !call_stb && !jmp && !lo_wr)
      |=> (fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1))); // R2
   AST_JMP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp && !ret && !call_stb)
      |=> (fetch_addr[OPND_W-1:0] == $past(opnd))
          && (fetch_addr[ADDR_W-1:OPND_W] == $past(latch_rd[OPND_W-REG_W+BLK_W-1:OPND_W-REG_W]))); // R3
   AST_LOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr && !ret && !call_stb && !jmp)
      |=> (fetch_addr == {$past(latch_rd[LATCH_W-1:0]), $past(wr_data)})); // R5
   AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ret |=> (fetch_addr == $past(pop_addr))); // R8
   AST_PUSH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      push_en |-> (push_addr == ADDR_W'(fetch_addr + 1'b1))); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(adv || jmp || call_stb || lo_wr || ret) |=> $stable(fetch_addr)); // R9
endmodule

// File: tb/tb_paged_pc.sv
`timescale 1ns/1ps
module tb_paged_pc;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        adv, jmp, call_stb, lo_wr, latch_wr, ret;
   logic [10:0] opnd;
   logic [7:0]  wr_data;
   logic [12:0] pop_addr;
   logic [12:0] fetch_addr, push_addr;
   logic        push_en;
   logic [7:0]  lo_rd, latch_rd;

   int n_vec  = 0;
   int n_fail = 0;

   // reference model state
   logic [12:0] m_pc  = '0;
   logic [4:0]  m_lat = '0;

   // scoreboard queues
   logic [12:0] q_pc[$];
   logic [4:0]  q_lat[$];
   string       q_tag[$];

   always #2 clk = ~clk;

   paged_pc dut (
      .clk(clk), .rst_n(rst_n), .adv(adv), .jmp(jmp), .call_stb(call_stb),
      .opnd(opnd), .lo_wr(lo_wr), .latch_wr(latch_wr), .wr_data(wr_data),
      .ret(ret), .pop_addr(pop_addr), .fetch_addr(fetch_addr),
      .push_addr(push_addr), .push_en(push_en), .lo_rd(lo_rd), .latch_rd(latch_rd)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // driver: applies one cycle of strobes, checks push, queues expected state
   task automatic drive(input logic a, input logic j, input logic c, input logic lw,
                        input logic lt, input logic r, input logic [10:0] op,
                        input logic [7:0] wd, input logic [12:0] pop, input string tag);
      logic [12:0] npc;
      @(negedge clk);
      adv = a; jmp = j; call_stb = c; lo_wr = lw; latch_wr = lt; ret = r;
      opnd = op; wr_data = wd; pop_addr = pop;
      #1;
      check({tag, " R4 push_en"}, {31'd0, push_en}, {31'd0, c & ~r});
      if (c && !r) check({tag, " R4 push_addr"}, {19'd0, push_addr}, {19'd0, 13'(m_pc + 1)});
      if (r)           npc = pop;
      else if (c || j) npc = {m_lat[4:3], op};
      else if (lw)     npc = {m_lat, wd};
      else if (a)      npc = 13'(m_pc + 1);
      else             npc = m_pc;
      if (lt) m_lat = wd[4:0];
      m_pc = npc;
      q_pc.push_back(m_pc);
      q_lat.push_back(m_lat);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input string tag);
      drive(0, 0, 0, 0, 0, 0, '0, '0, '0, tag);
   endtask

   // monitor: compares after each edge that follows a driven cycle
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_pc.size() > 0) begin
            logic [12:0] epc;
            logic [4:0]  elat;
            string       t;
            epc = q_pc.pop_front();
            elat = q_lat.pop_front();
            t = q_tag.pop_front();
            check({t, " fetch_addr"}, {19'd0, fetch_addr}, {19'd0, epc});
            check({t, " R6 latch_rd"}, {24'd0, latch_rd}, {27'd0, elat});
            check({t, " R7 lo_rd"}, {24'd0, lo_rd}, {24'd0, epc[7:0]});
         end
      end
   end

   // watchdog
   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      adv = 0; jmp = 0; call_stb = 0; lo_wr = 0; latch_wr = 0; ret = 0;
      opnd = '0; wr_data = '0; pop_addr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset fetch_addr", {19'd0, fetch_addr}, 32'd0);
      check("R1 reset latch_rd", {24'd0, latch_rd}, 32'd0);
      rst_n = 1'b1;

      // R6: latch load, upper bits read zero
      drive(0, 0, 0, 0, 1, 0, '0, 8'hFF, '0, "R6 latch=1F");
      // R5: computed jump to top page
      drive(0, 0, 0, 1, 0, 0, '0, 8'hFE, '0, "R5 lowwr FE");
      // R2: step and wrap
      drive(1, 0, 0, 0, 0, 0, '0, '0, '0, "R2 inc 1FFF");
      drive(1, 0, 0, 0, 0, 0, '0, '0, '0, "R2 wrap 0000");
      // R3: jump to end of block 1, then cross into block 2
      drive(0, 0, 0, 0, 1, 0, '0, 8'h0A, '0, "R6 latch=0A");
      drive(0, 1, 0, 0, 0, 0, 11'h7FF, '0, '0, "R3 jmp 0FFF");
      drive(1, 0, 0, 0, 0, 0, '0, '0, '0, "R2 block cross");
      // R4: call with new latch
      drive(0, 0, 0, 0, 1, 0, '0, 8'hF3, '0, "R6 latch=13 hi ignored");
      drive(0, 0, 1, 0, 0, 0, 11'h123, '0, '0, "R4 call 1123");
      // R5: computed jump to page 0x13
      drive(0, 0, 0, 1, 0, 0, '0, 8'h00, '0, "R5 lowwr 1300");
      // R8: return
      drive(0, 0, 0, 0, 0, 1, '0, '0, 13'h0ABC, "R8 ret 0ABC");
      // R9: priority ladder
      drive(1, 1, 1, 1, 0, 1, 11'h055, 8'h44, 13'h1555, "R9 ret wins");
      drive(1, 1, 1, 1, 0, 0, 11'h2AA, 8'h44, '0, "R9 call wins");
      drive(1, 1, 0, 1, 0, 0, 11'h011, 8'h44, '0, "R9 jmp wins");
      drive(1, 0, 0, 1, 0, 0, '0, 8'h77, '0, "R9 lowwr wins");
      idle("R9 hold");
      idle("R9 hold2");
      // R10: latch write together with jump and low write uses old latch
      drive(0, 1, 0, 0, 1, 0, 11'h400, 8'h08, '0, "R10 jmp old latch");
      drive(0, 1, 0, 0, 0, 0, 11'h400, '0, '0, "R10 jmp new latch");
      drive(0, 0, 0, 1, 1, 0, '0, 8'h1C, '0, "R10 lowwr old latch");
      // R4: call from 0x1FFF pushes 0x0000
      drive(0, 0, 0, 0, 1, 0, '0, 8'h1F, '0, "R6 latch=1F again");
      drive(0, 0, 0, 1, 0, 0, '0, 8'hFF, '0, "R5 lowwr 1FFF");
      drive(0, 0, 1, 0, 0, 0, 11'h000, '0, '0, "R4 call wrap push");
      // randomized mix against the model
      for (int i = 0; i < 300; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         drive(rv[0], rv[1] & rv[2], rv[3] & rv[4], rv[5] & rv[6], rv[7] & rv[8],
               rv[9] & rv[10] & rv[11], 11'($urandom), 8'($urandom), 13'($urandom),
               "R9 random mix");
      end
      idle("R9 final");
      @(posedge clk);
      @(posedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule